// File: doc/BRIEF.md
# Sign-Magnitude Clock Rate Calibrator

This block sits between a 32,768 Hz oscillator tick and the timekeeping counters that it drives. The tick arrives as a one-cycle enable pulse in a faster system clock domain. The block passes each tick on, one system clock later, as a corrected enable. It either drops ticks or adds extra ticks so that the long-run rate can be trimmed in both directions by software.

The trim has two parts: a 5-bit step count and a direction bit. Ticks are grouped into fixed correction windows. The default window holds 125,829,120 raw ticks, which is 64 minutes at the nominal rate. When the direction bit is 0, each step drops `SKIP_PER_STEP` ticks per window. The default of 256 slows the clock by about 2.03 ppm per step. When the direction bit is 1, each step adds `INS_PER_STEP` ticks per window. The default of 512 speeds the clock by about 4.07 ppm per step. The full span is therefore about +5.5 / −2.75 minutes per month. For example, an oscillator that runs 20 ppm fast is corrected with ten slowing steps.

Dropped or added ticks are placed on the first raw ticks of each window, with at most one correction per raw tick. The trim value is sampled only when a window opens. The raw enable must never be high on two consecutive system clocks.

Top module: `rate_calibrator`

## Requirements
- R1: While `rst` is high, `corr_en` is low. The first raw tick after reset opens a new window and samples `trim_mag` and `trim_dir` on that tick.
- R2: A raw tick (`osc_en` high) that is not dropped drives `corr_en` high for exactly one cycle, in the cycle after it is sampled.
- R3: When the sampled `trim_mag` is 0, every raw tick of the window is passed on, and the window yields exactly `WINDOW` output pulses.
- R4: When `trim_dir` = 0 (slow down), the first `trim_mag*SKIP_PER_STEP` raw ticks of the window produce no output. The window yields `WINDOW - trim_mag*SKIP_PER_STEP` pulses.
- R5: When `trim_dir` = 1 (speed up), each of the first `trim_mag*INS_PER_STEP` raw ticks of the window is followed by one extra `corr_en` cycle, directly after its normal output cycle. The window yields `WINDOW + trim_mag*INS_PER_STEP` pulses.
- R6: A change of `trim_mag` or `trim_dir` after a window has opened has no effect until the next window opens.
- R7: A window spans exactly `WINDOW` raw ticks. The next window opens on the tick that follows the last tick of the current window.
- R8: `corr_en` is never high unless, one cycle earlier, a raw tick was sampled or an added tick was pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Raw oscillator tick, one cycle wide, never on two consecutive cycles |
| trim_mag | input | 5 | Correction step count (0 to 31) |
| trim_dir | input | 1 | Correction direction: 1 adds ticks, 0 drops ticks |
| corr_en | output | 1 | Corrected tick enable |

## Verification
Ticks are sent with a fixed spacing, and the trim is varied window by window. A zero trim shows pure pass-through. A mid-range slowing trim and a mid-range speeding trim show that dropped ticks and added ticks each land on the leading part of the window and nowhere else. The full-scale value 31 in both directions tests the largest correction budget against the window length. A trim changed in the middle of a window tells apart a design that samples only at the window boundary from one that reacts at once. Per-window pulse tallies are compared against the expected totals.

// File: rtl/calib_pkg.sv
package calib_pkg;

   localparam int unsigned MAG_W    = 5;
   localparam int unsigned MAG_MAX  = (1 << MAG_W) - 1;

   typedef logic [MAG_W-1:0] trim_mag_t;

   typedef struct packed {
      trim_mag_t mag;
      logic      dir;   // 1 = add ticks, 0 = drop ticks
   } trim_t;

   function automatic int unsigned budget_bits(input int unsigned skip_step,
                                               input int unsigned ins_step);
      int unsigned big;
      big = (skip_step > ins_step) ? skip_step : ins_step;
      return $clog2(MAG_MAX * big + 1);
   endfunction

endpackage

// File: rtl/calib_window_ctr.sv
module calib_window_ctr #(
   parameter int unsigned WINDOW = 125829120,
   localparam int unsigned IDX_W = (WINDOW > 1) ? $clog2(WINDOW) : 1
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   output logic open_win
);

   logic [IDX_W-1:0] idx_q;

   assign open_win = tick && (idx_q == '0);

   generate
      if ((1 << IDX_W) == WINDOW) begin : g_pow2
         // natural wrap of the counter closes the window
         always_ff @(posedge clk) begin
            if (rst)       idx_q <= '0;
            else if (tick) idx_q <= idx_q + 1'b1;
         end
      end else begin : g_cmp
         localparam logic [IDX_W-1:0] LAST = IDX_W'(WINDOW - 1);
         always_ff @(posedge clk) begin
            if (rst)             idx_q <= '0;
            else if (tick) begin
               if (idx_q == LAST) idx_q <= '0;
               else               idx_q <= idx_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/calib_setting_reg.sv
module calib_setting_reg
   import calib_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  open_win,
   input  trim_t trim_in,
   output trim_t trim_q,
   output trim_t trim_eff
);

   always_ff @(posedge clk) begin
      if (rst)           trim_q <= '0;
      else if (open_win) trim_q <= trim_in;
   end

   // the opening tick already follows the new setting
   assign trim_eff = open_win ? trim_in : trim_q;

endmodule

// File: rtl/calib_budget.sv
module calib_budget
   import calib_pkg::*;
#(
   parameter int unsigned SKIP_PER_STEP = 256,
   parameter int unsigned INS_PER_STEP  = 512,
   localparam int unsigned BUD_W = budget_bits(SKIP_PER_STEP, INS_PER_STEP)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             open_win,
   input  trim_t            trim_eff,
   output logic             fix_now,
   output logic [BUD_W-1:0] budget_q
);

   localparam logic [BUD_W-1:0] SKIP_K = BUD_W'(SKIP_PER_STEP);
   localparam logic [BUD_W-1:0] INS_K  = BUD_W'(INS_PER_STEP);

   logic [BUD_W-1:0] load_val;
   logic [BUD_W-1:0] cur;

   always_comb begin
      load_val = BUD_W'(trim_eff.mag) * (trim_eff.dir ? INS_K : SKIP_K);
      cur      = open_win ? load_val : budget_q;
      fix_now  = tick && (cur != '0);
   end

   always_ff @(posedge clk) begin
      if (rst)       budget_q <= '0;
      else if (tick) budget_q <= cur - BUD_W'(fix_now);
   end

endmodule

// File: rtl/calib_out_stage.sv
module calib_out_stage (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic fix_now,
   input  logic dir,
   output logic add_pend,
   output logic corr_en
);

   always_ff @(posedge clk) begin
      if (rst) begin
         corr_en  <= 1'b0;
         add_pend <= 1'b0;
      end else begin
         corr_en  <= (tick && !(fix_now && !dir)) || add_pend;
         add_pend <= tick && fix_now && dir;
      end
   end

endmodule

// File: rtl/rate_calibrator.sv
module rate_calibrator
   import calib_pkg::*;
#(
   parameter int unsigned WINDOW        = 125829120,
   parameter int unsigned SKIP_PER_STEP = 256,
   parameter int unsigned INS_PER_STEP  = 512
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       osc_en,
   input  logic [4:0] trim_mag,
   input  logic       trim_dir,
   output logic       corr_en
);

   localparam int unsigned BUD_W = budget_bits(SKIP_PER_STEP, INS_PER_STEP);

   generate
      if (SKIP_PER_STEP * MAG_MAX > WINDOW) begin : g_bad_skip
         $error("full-scale drop budget exceeds window");
      end
      if (INS_PER_STEP * MAG_MAX > WINDOW) begin : g_bad_ins
         $error("full-scale add budget exceeds window");
      end
      if (WINDOW < 2) begin : g_bad_win
         $error("window too short");
      end
   endgenerate

   logic             open_win;
   logic             fix_now;
   logic             add_pend;
   logic [BUD_W-1:0] budget_q;
   trim_t            trim_in;
   trim_t            trim_q;
   trim_t            trim_eff;

   assign trim_in.mag = trim_mag;
   assign trim_in.dir = trim_dir;

   calib_window_ctr #(.WINDOW(WINDOW)) u_win (
      .clk(clk), .rst(rst), .tick(osc_en), .open_win(open_win)
   );

   calib_setting_reg u_set (
      .clk(clk), .rst(rst), .open_win(open_win), .trim_in(trim_in),
      .trim_q(trim_q), .trim_eff(trim_eff)
   );

   calib_budget #(.SKIP_PER_STEP(SKIP_PER_STEP), .INS_PER_STEP(INS_PER_STEP)) u_bud (
      .clk(clk), .rst(rst), .tick(osc_en), .open_win(open_win),
      .trim_eff(trim_eff), .fix_now(fix_now), .budget_q(budget_q)
   );

   calib_out_stage u_out (
      .clk(clk), .rst(rst), .tick(osc_en), .fix_now(fix_now),
      .dir(trim_eff.dir), .add_pend(add_pend), .corr_en(corr_en)
   );

endmodule

// File: rtl/rate_calibrator_chk.sv
module rate_calibrator_chk (
   input logic clk,
   input logic rst,
   input logic osc_en,
   input logic open_win,
   input logic fix_now,
   input logic add_pend,
   input logic corr_en,
   input logic [4:0] mag_q,
   input logic dir_q
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) rst |=> !corr_en);

   // R2
   pass_tick_chk: assert property (@(posedge clk) disable iff (rst)
      (osc_en && !fix_now) |=> corr_en);

   // R8
   no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
      (!osc_en && !add_pend) |=> !corr_en);

   // R6
   trim_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !open_win |=> ($stable(mag_q) && $stable(dir_q)));

   // R5
   add_follows_chk: assert property (@(posedge clk) disable iff (rst)
      add_pend |-> $past(osc_en));

endmodule

bind rate_calibrator rate_calibrator_chk i_chk (
   .clk(clk), .rst(rst), .osc_en(osc_en), .open_win(open_win),
   .fix_now(fix_now), .add_pend(add_pend), .corr_en(corr_en),
   .mag_q(trim_q.mag), .dir_q(trim_q.dir)
);

// File: tb/test_rate_calibrator.sv
`timescale 1ns/1ps
module test_rate_calibrator;

   localparam int W    = 64;
   localparam int SKIP = 1;
   localparam int INS  = 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       osc_en = 1'b0;
   logic [4:0] trim_mag = '0;
   logic       trim_dir = 1'b0;
   logic       corr_en;

   always #10 clk = ~clk;

   rate_calibrator #(.WINDOW(W), .SKIP_PER_STEP(SKIP), .INS_PER_STEP(INS)) i_rate_calibrator (
      .clk(clk), .rst(rst), .osc_en(osc_en), .trim_mag(trim_mag),
      .trim_dir(trim_dir), .corr_en(corr_en)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int out_count = 0;
   bit exp_q[$];
   int tag_q[$];

   // model state
   int m_idx = 0;
   int m_mag = 0;
   int m_dir = 0;
   int win_start_count = 0;
   int win_expect = -1;
   int win_tag = 0;

   // monitor: sample 5 ns after each rising edge
   always @(posedge clk) begin
      #5;
      if (corr_en === 1'b1) out_count++;
      if (exp_q.size() > 0) begin
         bit e;
         int t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_cmp++;
         if (corr_en !== e) begin
            n_bad++;
            $display("FAIL R%0d: corr_en actual=%b expected=%b at %0t", t, corr_en, e, $time);
         end
      end
   end

   task automatic idle_cycle(input bit e, input int t);
      @(negedge clk);
      osc_en = 1'b0;
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   // one raw tick followed by two idle cycles
   task automatic send_tick();
      int limit;
      bit fix;
      bit drop;
      int tg;
      @(negedge clk);
      if (m_idx == 0) begin
         // R7: window tally check at each boundary
         if (win_expect >= 0) begin
            n_cmp++;
            if (out_count - win_start_count != win_expect) begin
               n_bad++;
               $display("FAIL R%0d: window tally actual=%0d expected=%0d",
                        win_tag, out_count - win_start_count, win_expect);
            end
         end
         win_start_count = out_count;
         m_mag = trim_mag;
         m_dir = trim_dir;
         limit = m_mag * (m_dir ? INS : SKIP);
         win_expect = m_dir ? W + limit : W - limit;
         win_tag = (m_mag == 0) ? 3 : (m_dir ? 5 : 4);
      end
      limit = m_mag * (m_dir ? INS : SKIP);
      fix  = (m_idx < limit);
      drop = fix && (m_dir == 0);
      tg   = (m_mag == 0) ? 3 : (drop ? 4 : 2);
      osc_en = 1'b1;
      exp_q.push_back(!drop);
      tag_q.push_back(tg);
      m_idx = (m_idx + 1) % W;
      idle_cycle(fix && m_dir == 1, 5);
      idle_cycle(1'b0, 8);
   endtask

   task automatic run_window(input int mag, input bit dir);
      trim_mag = 5'(mag);
      trim_dir = dir;
      for (int i = 0; i < W; i++) send_tick();
   endtask

   bit done = 0;

   initial begin
      // R1: reset holds output low
      for (int i = 0; i < 5; i++) idle_cycle(1'b0, 1);
      @(negedge clk);
      rst = 1'b0;
      idle_cycle(1'b0, 1);
      run_window(0, 1'b0);   // R3
      run_window(5, 1'b0);   // R4
      run_window(7, 1'b1);   // R5
      run_window(31, 1'b0);  // R4 full scale
      run_window(31, 1'b1);  // R5 full scale
      // R6: change trim mid-window, applies only from the next window
      trim_mag = 5'd3;
      trim_dir = 1'b0;
      for (int i = 0; i < W / 2; i++) send_tick();
      trim_mag = 5'd9;
      trim_dir = 1'b1;
      for (int i = 0; i < W / 2; i++) send_tick();
      run_window(9, 1'b1);
      run_window(0, 1'b0);
      send_tick();           // closes last window, checks tally (R7)
      for (int i = 0; i < 4; i++) idle_cycle(1'b0, 8);
      @(negedge clk);
      @(negedge clk);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL R7: watchdog expired actual=hung expected=done");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule